// File: doc/BRIEF.md
# Dual-Source Clock Fanout with Glitch-Free Enable

This block picks one of two incoming clocks and copies the chosen clock onto a bank of matched true/complement output pairs. A select bit chooses the source: low picks the differential-origin clock, high picks the single-ended clock. Downstream logic can stop the fanned-out clock by raising an active-low enable line at any moment, with no timing relation to the clock.

The enable is resynchronized to the chosen clock in two stages. A register samples it on the rising edge. A latch that is transparent only while the clock is low then passes the sampled value on. The true outputs are the clock ANDed with the latch, and the complement outputs are the matching NAND. The gate can only open or close during the low phase, so every pulse that reaches an output has the full high width of the input clock. While the bank is stopped, the true outputs rest low and the complements rest high.

Top module: `scef_fanout`

## Requirements
- R1: With `src_sel_i` = 1 the outputs are driven from `clk_se_i`; with `src_sel_i` = 0 they are driven from `clk_diff_i`.
- R2: While enabled, each true output equals the selected clock (high in its high phase, low in its low phase) and each complement output is its inverse.
- R3: While disabled, every true output is 0 and every complement output is 1 through both clock phases, for either source.
- R4: A change on `stop_n_i`... is applied only after one rising edge and then one falling edge of the selected clock. A change made between rising edges k-1 and k first shows in the high phase that starts at rising edge k+1.
- R5: No output produces a shortened pulse. Each high pulse on a true output lasts the whole high phase of the selected clock, and the gate state never changes while that clock is high.
- R6: All `N_OUT` pairs (default 5) carry the same value at all times. Bit i of `out_t_o` and bit i of `out_c_o` form pair i, and the path from clock to true output is non-inverting.
- R7: Each complement output is the exact logical inverse of its true output in every state, including disabled.
- R8: While `rst_n_i` is 0 the block is disabled (true outputs 0, complements 1). After release it remains disabled until the current enable level has passed the R4 latency, counted from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_diff_i | input | 1 | Clock source chosen when the select bit is 0 |
| clk_se_i | input | 1 | Clock source chosen when the select bit is 1 |
| src_sel_i | input | 1 | Source select |
| stop_n_i | input | 1 | Active-low output enable, asynchronous to both clocks |
| rst_n_i | input | 1 | Active-low asynchronous reset, forces the disabled state |
| out_t_o | output | N_OUT | True outputs, one bit per pair |
| out_c_o | output | N_OUT | Complement outputs, one bit per pair |

Note on R4: the signal named there is `stop_n_i`, written without the trailing dots.

## Verification
The assertions watch the structural properties on every cycle. They check that the latch is equal to the sampling register at each rising edge, that the latch only moves while the clock is low, that a closed gate holds the true outputs low through the high phase, and that the pairs agree with each other and with their complements. Some properties only the bench's scenarios can show. These are the exact two-edge latency after enable changes placed at random points in the clock period, the full-width pulses seen at the ports early and late in each high phase, the effect of the source select, and the disabled start after reset. The bench checks these against a queue of expected gate states that its own driver fills.

// File: rtl/scef_pkg.sv
`timescale 1ns/1ps
package scef_pkg;

  // Gate arithmetic for one output pair, kept apart so each side is built independently.
  function automatic logic pair_true(input logic clk, input logic open);
    return clk & open;
  endfunction

  function automatic logic pair_comp(input logic clk, input logic open);
    return ~clk | ~open;
  endfunction

endpackage

// File: rtl/scef_src_pick.sv
`timescale 1ns/1ps
module scef_src_pick (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  output logic clk_o
);

  // R1: low selects clk_a_i, high selects clk_b_i
  assign clk_o = sel_i ? clk_b_i : clk_a_i;

endmodule

// File: rtl/scef_en_resync.sv
`timescale 1ns/1ps
module scef_en_resync (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic stop_n_i,
  output logic gate_open_o
);

  logic cap_q;   // enable sampled on rising edge
  logic lat_q;   // passed through while clock is low

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cap_q <= 1'b0;
    else          cap_q <= ~stop_n_i;
  end

  always_latch begin
    if (!rst_n_i)    lat_q <= 1'b0;
    else if (!clk_i) lat_q <= cap_q;
  end

  assign gate_open_o = lat_q;

  // R4: at every rising edge the latch has caught up with the sampling register
  a_r4_latch_caught_up: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lat_q == cap_q)
    else $error("latch differs from capture register at rising edge");

  // R5: the gate state only moves in the low phase of the clock
  always @(lat_q) begin
    if (rst_n_i) begin
      a_r5_moves_when_low: assert (!clk_i)
        else $error("gate changed while clock high");
    end
  end

endmodule

// File: rtl/scef_pair_drv.sv
`timescale 1ns/1ps
module scef_pair_drv #(
  parameter int N_OUT = 5
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             gate_open_i,
  output logic [N_OUT-1:0] out_t_o,
  output logic [N_OUT-1:0] out_c_o
);
  import scef_pkg::*;

  localparam logic [N_OUT-1:0] ALL_ONE = {N_OUT{1'b1}};

  for (genvar g = 0; g < N_OUT; g++) begin : g_pair
    assign out_t_o[g] = pair_true(clk_i, gate_open_i);
    assign out_c_o[g] = pair_comp(clk_i, gate_open_i);
  end

  // R3: a closed gate keeps true outputs low across the high phase
  a_r3_closed_low: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    !gate_open_i |-> out_t_o == '0)
    else $error("true output high while gate closed");

  // R7: complement is the inverse of true, checked in both phases
  a_r7_inverse_hi: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    out_c_o == ~out_t_o)
    else $error("complement not inverse (high phase)");

  a_r7_inverse_lo: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    out_c_o == ~out_t_o)
    else $error("complement not inverse (low phase)");

  // R6: all pairs agree
  a_r6_pairs_match: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (out_t_o == '0) || (out_t_o == ALL_ONE))
    else $error("output pairs disagree");

endmodule

// File: rtl/scef_fanout.sv
`timescale 1ns/1ps
module scef_fanout #(
  parameter int N_OUT = 5
) (
  input  logic             clk_diff_i,
  input  logic             clk_se_i,
  input  logic             src_sel_i,
  input  logic             stop_n_i,
  input  logic             rst_n_i,
  output logic [N_OUT-1:0] out_t_o,
  output logic [N_OUT-1:0] out_c_o
);

  logic clk_pick;     // selected source clock
  logic gate_open;    // resynchronized enable, changes only in low phase

  scef_src_pick u_pick (
    .clk_a_i (clk_diff_i),
    .clk_b_i (clk_se_i),
    .sel_i   (src_sel_i),
    .clk_o   (clk_pick)
  );

  scef_en_resync u_sync (
    .clk_i       (clk_pick),
    .rst_n_i     (rst_n_i),
    .stop_n_i    (stop_n_i),
    .gate_open_o (gate_open)
  );

  scef_pair_drv #(.N_OUT(N_OUT)) u_drv (
    .clk_i       (clk_pick),
    .rst_n_i     (rst_n_i),
    .gate_open_i (gate_open),
    .out_t_o     (out_t_o),
    .out_c_o     (out_c_o)
  );

endmodule

// File: tb/scef_fanout_bench.sv
`timescale 1ns/1ps
module scef_fanout_bench;
  localparam int N = 5;

  logic clk_diff = 1'b0;
  logic clk_se   = 1'b0;
  logic src_sel  = 1'b0;
  logic stop_n   = 1'b0;
  logic rst_n    = 1'b0;
  logic [N-1:0] out_t, out_c;

  always #5 clk_diff = ~clk_diff;   // 100 MHz
  always #8 clk_se   = ~clk_se;

  scef_fanout #(.N_OUT(N)) u_scef_fanout (
    .clk_diff_i (clk_diff),
    .clk_se_i   (clk_se),
    .src_sel_i  (src_sel),
    .stop_n_i   (stop_n),
    .rst_n_i    (rst_n),
    .out_t_o    (out_t),
    .out_c_o    (out_c)
  );

  wire bclk = src_sel ? clk_se : clk_diff;

  typedef struct { logic stop_n; int at; } item_t;
  item_t q[$];

  int  n_tests = 0;
  int  n_fail  = 0;
  int  k       = 0;
  int  hp      = 5;
  int  last_at = 0;
  bit  run     = 0;
  bit  done    = 0;
  bit  exp_on  = 0;

  task automatic chk(input string tag, input logic [N-1:0] et);
    n_tests++;
    if (out_t !== et || out_c !== ~et) begin
      n_fail++;
      $display("FAIL %s: true=%b comp=%b expected true=%b comp=%b",
               tag, out_t, out_c, et, ~et);
    end
  endtask

  // monitor: pops expected gate states as edges arrive
  always @(posedge bclk) begin
    string tag;
    logic [N-1:0] et;
    k++;
    if (run) begin
      while (q.size() > 0 && q[0].at <= k) begin
        exp_on  = !q[0].stop_n;
        last_at = q[0].at;
        void'(q.pop_front());
      end
      et = exp_on ? '1 : '0;
      if (k == last_at || k == last_at + 1) tag = "R4 R8 edge latency";
      else if (!exp_on) tag = "R3 disabled";
      else tag = src_sel ? "R1 R2 R6 single-ended source" : "R1 R2 R6 differential source";
      #1;      chk(tag, et);
      #(hp-2); chk({"R5 R7 late high, ", tag}, et);
      #2;      chk("R2 R7 low phase", '0);
    end
  end

  task automatic toggle();
    repeat ($urandom_range(0, 3)) @(posedge bclk);
    @(posedge bclk);
    #($urandom_range(1, 2*hp-1));
    stop_n = ~stop_n;
    q.push_back('{stop_n, k + 2});
  endtask

  task automatic phase(input logic sel);
    run = 0;
    rst_n = 1'b0;
    src_sel = sel;
    stop_n = 1'b0;
    hp = sel ? 8 : 5;
    q.delete();
    exp_on = 0;
    repeat (3) @(posedge bclk);
    #2; chk("R8 reset high phase", '0);
    #(hp); chk("R8 reset low phase", '0);
    @(posedge bclk);
    #($urandom_range(1, 2*hp-1));
    rst_n = 1'b1;
    q.push_back('{stop_n, k + 2});
    run = 1;
    for (int i = 0; i < 24; i++) toggle();
    if (stop_n) toggle();   // finish enabled
    repeat (4) @(posedge bclk);
    #(2*hp - 2);
    run = 0;
  endtask

  initial begin
    #23;
    phase(1'b0);
    phase(1'b1);
    phase(1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule